// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block connects one pre-processing channel to a host processor's shared 16-bit multiplexed address/data bus. Up to eight such slaves hang on one bus. The host first places an address on the shared lines and pulses the address-latch strobe. Each slave captures that address and decodes it against its own 3-bit channel number. After that the host runs a read strobe or a write strobe phase, and the lines then carry data.

When a slave is addressed during a read, it drives a 16-bit word toward the host. The word is one of three things: the channel's latest sample, a status word with a "new sample" flag, or a readback of its control register. At every other time its output enable stays low, so another slave or the host can own the lines. A write to the slave's control address loads a 16-bit control register, which is presented to the channel logic.

The strobes arrive asynchronously from the host. Each one passes through a synchronizer chain before any edge is acted on. The host must therefore hold the address, and the write data, a few local clocks past the end of each strobe.

Top module: `mpb_slave`

## Requirements
- R1: After reset, `ad_oe_o` is 0, `ad_o` is 0, `ctrl_o` equals parameter `CTRL_RST` (default 0), and the new-sample flag is 0.
- R2: The address is captured from `ad_i` on the synchronized falling edge of `ale_i` and held until the next such edge. Bus activity in between does not change the decode.
- R3: Address decode. Bits [2:0] must equal `chan_id_i`, bit 3 must be 0, and bits [15:6] must be 0. Bits [5:4] select the register: 0 is the sample, 1 is the status, 2 is control, and 3 is reserved and never selected.
- R4: `ad_oe_o` is 1 only while a read strobe is active and the latched address selects a readable register. Whenever `ad_oe_o` is 0, `ad_o` is 0.
- R5: The read word is captured when the read strobe starts and holds steady until the strobe ends, even if a new sample arrives during the strobe.
- R6: At the end of a write strobe to the control address, `ctrl_o` loads the value on `ad_i`. Writes to any other address leave it unchanged.
- R7: The status word carries the new-sample flag in bit 0 and zeros in bits [15:1]. A pulse on `sample_valid_i` stores `sample_i` and sets the flag.
- R8: The flag clears when a sample read starts. Status and control reads leave it unchanged. A sample arriving in the same cycle as the clear, or later, sets the flag again.
- R9: With `SYNC_STAGES`=2, `ad_oe_o` rises on the third clock edge after `rd_i` rises, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_id_i | input | 3 | This slave's channel number |
| ale_i | input | 1 | Address latch strobe from host, active high |
| rd_i | input | 1 | Read strobe from host, active high |
| wr_i | input | 1 | Write strobe from host, active high |
| ad_i | input | 16 | Bus lines as seen by the slave |
| ad_o | output | 16 | Word driven toward the bus |
| ad_oe_o | output | 1 | Bus driver enable |
| sample_i | input | 16 | Latest channel result |
| sample_valid_i | input | 1 | One-cycle pulse marking a new result |
| ctrl_o | output | 16 | Control register contents |

## Verification
The embedded assertions cover the invariant properties on every cycle:
- the address register changes only on a detected address-strobe fall;
- the control register changes only on a qualifying write end;
- the output is zero whenever the driver is off, and the driver is only on after an active read;
- the driven word stays steady while the driver stays on;
- the flag is set after any sample pulse and falls only after a sample read starts.

Other behaviour can only be shown by the bench's bus cycles:
- the decode of each address field against the channel number;
- readback of control values after writes;
- that a write to a neighbour's address is ignored;
- that a sample arriving mid-read leaves the frozen word unchanged and re-arms the flag;
- the exact three-edge read latency.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [1:0] {
    REG_SAMPLE = 2'd0,
    REG_STATUS = 2'd1,
    REG_CTRL   = 2'd2,
    REG_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mpb_strobe_sync.sv
module mpb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= strobe_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~last_q;
  assign fall_o  = ~level_o & last_q;
endmodule

// File: rtl/mpb_addr_decode.sv
module mpb_addr_decode
  import mpb_pkg::*;
#(
  parameter int AD_W    = 16,
  parameter int ID_W    = 3,
  parameter int SEL_LSB = 4,
  parameter int SEL_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_fall_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [ID_W-1:0] chan_id_i,
  output logic            match_o,
  output reg_sel_e        sel_o
);
  localparam logic [AD_W-1:0] ID_MASK  = AD_W'((1 << ID_W) - 1);
  localparam logic [AD_W-1:0] SEL_MASK = AD_W'(((1 << SEL_W) - 1) << SEL_LSB);
  localparam logic [AD_W-1:0] PAD_MASK = ~(ID_MASK | SEL_MASK);

  logic [AD_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         addr_q <= '1;
    else if (ale_fall_i) addr_q <= ad_i;

  assign sel_o   = reg_sel_e'(addr_q[SEL_LSB +: SEL_W]);
  assign match_o = (addr_q[ID_W-1:0] == chan_id_i) && ((addr_q & PAD_MASK) == '0);

  // R2: address held between strobes
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_fall_i |=> $stable(addr_q));
endmodule

// File: rtl/mpb_regs.sv
module mpb_regs
  import mpb_pkg::*;
#(
  parameter int                 AD_W     = 16,
  parameter logic [AD_W-1:0]    CTRL_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            match_i,
  input  reg_sel_e        sel_i,
  input  logic            rd_rise_i,
  input  logic            wr_fall_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [AD_W-1:0] sample_i,
  input  logic            sample_valid_i,
  output logic [AD_W-1:0] word_o,
  output logic            readable_o,
  output logic [AD_W-1:0] ctrl_o
);
  logic [AD_W-1:0] sample_q, ctrl_q;
  logic            fresh_q;
  logic            wr_hit, sample_rd;

  assign wr_hit    = wr_fall_i && match_i && (sel_i == REG_CTRL);
  assign sample_rd = rd_rise_i && match_i && (sel_i == REG_SAMPLE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             sample_q <= '0;
    else if (sample_valid_i) sample_q <= sample_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ctrl_q <= CTRL_RST;
    else if (wr_hit) ctrl_q <= ad_i;

  // new sample wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             fresh_q <= 1'b0;
    else if (sample_valid_i) fresh_q <= 1'b1;
    else if (sample_rd)      fresh_q <= 1'b0;

  always_comb begin
    unique case (sel_i)
      REG_SAMPLE: word_o = sample_q;
      REG_STATUS: word_o = {{(AD_W-1){1'b0}}, fresh_q};
      REG_CTRL:   word_o = ctrl_q;
      default:    word_o = '0;
    endcase
  end

  assign readable_o = match_i && (sel_i != REG_RSVD);
  assign ctrl_o     = ctrl_q;

  // R6: control changes only on a qualifying write end
  p_ctrl_only_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fall_i && match_i && sel_i == REG_CTRL) |=> $stable(ctrl_q));
  // R7: a sample pulse always leaves the flag set
  p_fresh_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> fresh_q);
  // R8: flag falls only after a sample read starts
  p_fresh_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fresh_q) |-> $past(rd_rise_i && match_i && sel_i == REG_SAMPLE));
endmodule

// File: rtl/mpb_read_port.sv
module mpb_read_port #(
  parameter int AD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_level_i,
  input  logic            rd_rise_i,
  input  logic            readable_i,
  input  logic [AD_W-1:0] word_i,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o
);
  logic [AD_W-1:0] hold_q;
  logic            oe_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else if (rd_rise_i) begin
      hold_q <= word_i;
      oe_q   <= readable_i;
    end else if (!rd_level_i) begin
      oe_q   <= 1'b0;
    end

  assign ad_oe_o = oe_q;
  assign ad_o    = oe_q ? hold_q : '0;

  // R5: driven word steady across the strobe
  p_word_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && $past(oe_q)) |-> $stable(ad_o));
  // R9: driver turns on only following a detected read start
  p_oe_after_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(rd_rise_i));
endmodule

// File: rtl/mpb_slave.sv
module mpb_slave
  import mpb_pkg::*;
#(
  parameter int              AD_W        = 16,
  parameter int              ID_W        = 3,
  parameter int              SEL_LSB     = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [AD_W-1:0] CTRL_RST    = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] chan_id_i,
  input  logic            ale_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [AD_W-1:0] ad_i,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o,
  input  logic [AD_W-1:0] sample_i,
  input  logic            sample_valid_i,
  output logic [AD_W-1:0] ctrl_o
);
  localparam int SEL_W = $bits(reg_sel_e);
  localparam int N_STB = 3;

  logic [N_STB-1:0] stb_in, stb_lvl, stb_rise, stb_fall;
  logic             match, readable;
  reg_sel_e         sel;
  logic [AD_W-1:0]  word;

  assign stb_in = {wr_i, rd_i, ale_i};

  generate
    for (genvar s = 0; s < N_STB; s++) begin : g_sync
      mpb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(stb_in[s]),
        .level_o (stb_lvl[s]),
        .rise_o  (stb_rise[s]),
        .fall_o  (stb_fall[s])
      );
    end
  endgenerate

  mpb_addr_decode #(.AD_W(AD_W), .ID_W(ID_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ale_fall_i(stb_fall[0]),
    .ad_i      (ad_i),
    .chan_id_i (chan_id_i),
    .match_o   (match),
    .sel_o     (sel)
  );

  mpb_regs #(.AD_W(AD_W), .CTRL_RST(CTRL_RST)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .match_i       (match),
    .sel_i         (sel),
    .rd_rise_i     (stb_rise[1]),
    .wr_fall_i     (stb_fall[2]),
    .ad_i          (ad_i),
    .sample_i      (sample_i),
    .sample_valid_i(sample_valid_i),
    .word_o        (word),
    .readable_o    (readable),
    .ctrl_o        (ctrl_o)
  );

  mpb_read_port #(.AD_W(AD_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_level_i(stb_lvl[1]),
    .rd_rise_i (stb_rise[1]),
    .readable_i(readable),
    .word_i    (word),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o)
  );

  // R4: quiet output when released; driver implies a read strobe
  p_quiet_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> (ad_o == '0));
  p_oe_needs_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(stb_lvl[1]));
endmodule

// File: tb/tb_mpb_slave.sv
module tb_mpb_slave;
  localparam int          AD_W = 16;
  localparam logic [2:0]  CHAN = 3'd5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      chan_id_i = CHAN;
  logic            ale_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [AD_W-1:0] ad_i = '0;
  logic [AD_W-1:0] ad_o;
  logic            ad_oe_o;
  logic [AD_W-1:0] sample_i = '0;
  logic            sample_valid_i = 1'b0;
  logic [AD_W-1:0] ctrl_o;

  int checks = 0, errors = 0;
  logic [AD_W-1:0] exp_sample = '0, exp_ctrl = '0;
  logic            exp_fresh = 1'b0;
  logic            done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mpb_slave dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [AD_W-1:0] addr_of(input logic [2:0] id, input logic [1:0] sel);
    return {10'd0, sel, 1'b0, id};
  endfunction

  // bench decode: 0=none 1=sample 2=status 3=ctrl
  function automatic int decode(input logic [AD_W-1:0] a);
    if (a[2:0] != CHAN || a[3] || a[15:6] != 0 || a[5:4] == 2'd3) return 0;
    return int'(a[5:4]) + 1;
  endfunction

  task automatic ale_phase(input logic [AD_W-1:0] a);
    @(negedge clk_i); ad_i = a; ale_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ale_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic do_read(input logic [AD_W-1:0] a, output logic oe, output logic [AD_W-1:0] d);
    ale_phase(a);
    ad_i = 16'($urandom);
    rd_i = 1'b1;
    repeat (6) @(negedge clk_i);
    oe = ad_oe_o; d = ad_o;
    rd_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic do_write(input logic [AD_W-1:0] a, input logic [AD_W-1:0] v);
    ale_phase(a);
    ad_i = v; wr_i = 1'b1;
    repeat (6) @(negedge clk_i);
    wr_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic push_sample(input logic [AD_W-1:0] v);
    @(negedge clk_i); sample_i = v; sample_valid_i = 1'b1;
    @(negedge clk_i); sample_valid_i = 1'b0;
    exp_sample = v; exp_fresh = 1'b1;
  endtask

  // model-checked read
  task automatic model_read(input string req, input logic [AD_W-1:0] a);
    logic oe; logic [AD_W-1:0] d; int k;
    k = decode(a);
    do_read(a, oe, d);
    check(req, {31'd0, oe}, {31'd0, k != 0});
    case (k)
      1: begin check(req, d, exp_sample); exp_fresh = 1'b0; end
      2: check(req, d, {15'd0, exp_fresh});
      3: check(req, d, exp_ctrl);
      default: check(req, d, 0);
    endcase
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic oe; logic [AD_W-1:0] d; logic [AD_W-1:0] a;
    int dummy;
    dummy = $urandom(32'd7);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 oe", {31'd0, ad_oe_o}, 0);
    check("R1 data", ad_o, 0);
    check("R1 ctrl", ctrl_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    model_read("R1 status after reset", addr_of(CHAN, 2'd1));

    // R7/R8 flag behaviour
    push_sample(16'hA5C3);
    model_read("R7 status set", addr_of(CHAN, 2'd1));
    model_read("R8 status read keeps flag", addr_of(CHAN, 2'd1));
    model_read("R4 sample read", addr_of(CHAN, 2'd0));
    model_read("R8 cleared after sample read", addr_of(CHAN, 2'd1));

    // R6 writes
    do_write(addr_of(CHAN, 2'd2), 16'h1234); exp_ctrl = 16'h1234;
    check("R6 ctrl_o", ctrl_o, exp_ctrl);
    model_read("R6 ctrl readback", addr_of(CHAN, 2'd2));
    do_write(addr_of(3'd2, 2'd2), 16'hFFFF);
    check("R6 other channel write ignored", ctrl_o, exp_ctrl);
    do_write(addr_of(CHAN, 2'd0), 16'h0F0F);
    check("R6 sample address write ignored", ctrl_o, exp_ctrl);

    // R3 decode corners
    model_read("R3 reserved select", addr_of(CHAN, 2'd3));
    model_read("R3 bit3 set", addr_of(CHAN, 2'd0) | 16'h0008);
    model_read("R3 upper bit set", addr_of(CHAN, 2'd0) | 16'h8000);
    model_read("R3 other channel", addr_of(3'd4, 2'd0));

    // R9 latency and R5 freeze, R2 hold
    push_sample(16'h0BEE);
    ale_phase(addr_of(CHAN, 2'd0));
    ad_i = 16'h0003; // bus now looks like another channel
    rd_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9 oe not yet", {31'd0, ad_oe_o}, 0);
    @(negedge clk_i);
    check("R9 oe on third edge", {31'd0, ad_oe_o}, 1);
    check("R2 address held", ad_o, 16'h0BEE);
    exp_fresh = 1'b0;
    sample_i = 16'h7777; sample_valid_i = 1'b1;
    @(negedge clk_i); sample_valid_i = 1'b0;
    exp_sample = 16'h7777; exp_fresh = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R5 frozen word", ad_o, 16'h0BEE);
    rd_i = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R4 released", {31'd0, ad_oe_o}, 0);
    model_read("R8 re-armed by mid-read sample", addr_of(CHAN, 2'd1));
    model_read("R5 new sample after read", addr_of(CHAN, 2'd0));

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op;
      op = int'($urandom % 4);
      if ($urandom % 2) a = addr_of(3'($urandom), 2'($urandom));
      else if ($urandom % 2) a = addr_of(CHAN, 2'($urandom));
      else a = 16'($urandom);
      case (op)
        0: push_sample(16'($urandom));
        1: begin
          d = 16'($urandom);
          do_write(a, d);
          if (decode(a) == 3) exp_ctrl = d;
          check("R6 random ctrl_o", ctrl_o, exp_ctrl);
        end
        default: model_read("R3 random read", a);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule